// File: doc/BRIEF.md
# Dual-Slot Instruction Retirement Checker

This block sits at the head of an in-order completion queue and decides, every clock, whether the oldest entry retires alone, retires together with the entry behind it, or raises an exception and retires nothing. A small queue model is built around the decision logic. Entries are pushed in program order, marked finished later by tag, and have their speculation marks cleared when the outstanding branch resolves. The queue head advances by the number of entries retired, so that retirement order can be observed.

The oldest entry retires as soon as it is valid and finished with no exception. The second entry may retire alongside it only if it is ready in its own right, is of a class the fast retirement path accepts, and keeps the combined register-file write counts of the pair within the write-port limit. Retirement results are registered. In the cycle after a decision, the retire strobes, the pop count and the tag of the oldest retired entry appear together at the outputs.

Top module: `retire_pair_unit`

## Requirements
- R1: After reset the queue is empty, and retire0, retire1 and excStrobe are 0, popCount is 0 and retireTag is 0.
- R2: When the head entry is valid, finished and has no exception, retire0 is 1 on the clock edge that follows the decision cycle, and popCount is at least 1.
- R3: When the head entry is valid and finished with its exception flag set, excStrobe is 1, retire0 and retire1 are 0 and popCount is 0, and the entry stays at the head.
- R4: retire1 is never 1 unless retire0 is 1 in the same cycle.
- R5: The second entry does not retire with the head unless it is already finished.
- R6: The second entry does not retire while its speculation mark (pushSpec=1) is set. A resolve pulse clears the mark on every entry in the queue.
- R7: The second entry does not retire with the head when its exception flag is set.
- R8: The second entry retires with the head only if its class is integer (pushClass=0) or load (pushClass=1). Store=2, float=3, branch=4 and system=5 keep it back.
- R9: A pair retires only if the sum of the two condition-register update counts is at most 2.
- R10: A pair retires only if the sum of the two general-register update counts is at most 2.
- R11: A pair retires only if the sum of the two float-register update counts is at most 2.
- R12: An invalid head entry retires nothing, and an invalid second entry does not retire. In particular, an empty queue never strobes.
- R13: popCount equals retire0 plus retire1. retireTag is the tag of the oldest retired entry. Tags are assigned from 0 in push order and wrap modulo the queue depth, and the head advances by popCount, so successive retirements report consecutive tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Append an entry at the tail (dropped if the queue is full) |
| pushFinished | input | 1 | Entry is already finished when pushed |
| pushExc | input | 1 | Entry carries an exception |
| pushSpec | input | 1 | Entry is younger than an unresolved predicted branch |
| pushClass | input | 3 | Instruction class: 0 int, 1 load, 2 store, 3 float, 4 branch, 5 system |
| pushCr | input | 2 | Condition-register update count |
| pushGpr | input | 2 | General-register update count |
| pushFpr | input | 2 | Float-register update count |
| finishValid | input | 1 | Mark the entry at finishTag finished |
| finishTag | input | TAG_W | Tag of the entry to mark finished |
| resolve | input | 1 | Clear the speculation mark on all entries |
| retire0 | output | 1 | Head entry retired |
| retire1 | output | 1 | Second entry retired with the head |
| excStrobe | output | 1 | Head entry blocked by its exception |
| popCount | output | 2 | Number of entries retired (0 to 2) |
| retireTag | output | TAG_W | Tag of the head entry at the decision |

## Verification
Two functions can act in one cycle: retirement of the head and retirement of the second entry. The second outcome is conditional on the first. The bench sets up each pair by pushing an unfinished head and a prepared second entry, then finishing the head. Both entries then reach the decision in the same cycle, under one varied condition: class, finish state, speculation, exception, or the count for one register file at the limit and one past it. A scoreboard model predicts whether the pair retires as one two-entry pop or as two one-entry pops with consecutive tags, and compares each retirement event against that prediction.

// File: rtl/retire_pkg.sv
package retire_pkg;
  localparam int CNT_W = 2;

  typedef enum logic [2:0] {
    CLS_INT    = 3'd0,
    CLS_LOAD   = 3'd1,
    CLS_STORE  = 3'd2,
    CLS_FLOAT  = 3'd3,
    CLS_BRANCH = 3'd4,
    CLS_SYSTEM = 3'd5
  } instClass_e;

  typedef struct packed {
    logic             valid;
    logic             finished;
    logic             exc;
    logic             spec;
    instClass_e       cls;
    logic [CNT_W-1:0] crCnt;
    logic [CNT_W-1:0] gprCnt;
    logic [CNT_W-1:0] fprCnt;
  } slot_t;

  typedef struct packed {
    logic take0;
    logic take1;
    logic raiseExc;
  } retireCtl_t;
endpackage

// File: rtl/retire_ctrl.sv
module retire_ctrl
  import retire_pkg::*;
#(
  parameter int MAX_UPD = 2
) (
  input  slot_t      slot0,
  input  slot_t      slot1,
  output retireCtl_t ctl
);
  localparam int SUM_W = CNT_W + 1;

  function automatic logic fitsLimit(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    logic [SUM_W-1:0] total;
    total = {1'b0, a} + {1'b0, b};
    return total <= SUM_W'(MAX_UPD);
  endfunction

  logic headReady;
  logic youngReady;
  logic classOk;
  logic portsOk;

  always_comb begin
    headReady  = slot0.valid && slot0.finished && !slot0.exc;
    youngReady = slot1.valid && slot1.finished && !slot1.exc && !slot1.spec;
    classOk    = (slot1.cls == CLS_INT) || (slot1.cls == CLS_LOAD);
    portsOk    = fitsLimit(slot0.crCnt, slot1.crCnt)
              && fitsLimit(slot0.gprCnt, slot1.gprCnt)
              && fitsLimit(slot0.fprCnt, slot1.fprCnt);
    ctl.take0    = headReady;
    ctl.take1    = headReady && youngReady && classOk && portsOk;
    ctl.raiseExc = slot0.valid && slot0.finished && slot0.exc;
  end
endmodule

// File: rtl/retire_queue.sv
module retire_queue
  import retire_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  slot_t            pushEntry,
  input  logic             finishValid,
  input  logic [TAG_W-1:0] finishTag,
  input  logic             resolve,
  input  retireCtl_t       ctl,
  output slot_t            headSlot0,
  output slot_t            headSlot1,
  output logic             retire0,
  output logic             retire1,
  output logic             excStrobe,
  output logic [1:0]       popCount,
  output logic [TAG_W-1:0] retireTag
);
  localparam int DEPTH = 1 << TAG_W;

  slot_t            entries [DEPTH];
  logic [TAG_W-1:0] headPtr;
  logic [TAG_W-1:0] headNext;
  logic [TAG_W-1:0] tailPtr;
  logic             pushAccept;
  logic [1:0]       popNow;

  assign headNext   = headPtr + TAG_W'(1);
  assign pushAccept = pushValid && !entries[tailPtr].valid;
  assign popNow     = {1'b0, ctl.take0} + {1'b0, ctl.take1};
  assign headSlot0  = entries[headPtr];
  assign headSlot1  = entries[headNext];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    slot_t ent;
    logic  popHere;
    assign popHere = (ctl.take0 && headPtr == TAG_W'(i)) || (ctl.take1 && headNext == TAG_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ent <= '0;
      end else begin
        if (resolve) ent.spec <= 1'b0;
        if (finishValid && finishTag == TAG_W'(i)) ent.finished <= 1'b1;
        if (popHere) ent.valid <= 1'b0;
        if (pushAccept && tailPtr == TAG_W'(i)) ent <= pushEntry;
      end
    end
    assign entries[i] = ent;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      retire0   <= 1'b0;
      retire1   <= 1'b0;
      excStrobe <= 1'b0;
      popCount  <= '0;
      retireTag <= '0;
    end else begin
      headPtr   <= headPtr + TAG_W'(popNow);
      if (pushAccept) tailPtr <= tailPtr + TAG_W'(1);
      retire0   <= ctl.take0;
      retire1   <= ctl.take1;
      excStrobe <= ctl.raiseExc;
      popCount  <= popNow;
      retireTag <= headPtr;
    end
  end
endmodule

// File: rtl/retire_pair_unit.sv
module retire_pair_unit
  import retire_pkg::*;
#(
  parameter int TAG_W   = 3,
  parameter int MAX_UPD = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic             pushFinished,
  input  logic             pushExc,
  input  logic             pushSpec,
  input  logic [2:0]       pushClass,
  input  logic [1:0]       pushCr,
  input  logic [1:0]       pushGpr,
  input  logic [1:0]       pushFpr,
  input  logic             finishValid,
  input  logic [TAG_W-1:0] finishTag,
  input  logic             resolve,
  output logic             retire0,
  output logic             retire1,
  output logic             excStrobe,
  output logic [1:0]       popCount,
  output logic [TAG_W-1:0] retireTag
);
  slot_t      pushEntry;
  slot_t      headSlot0;
  slot_t      headSlot1;
  retireCtl_t ctl;

  always_comb begin
    pushEntry.valid    = 1'b1;
    pushEntry.finished = pushFinished;
    pushEntry.exc      = pushExc;
    pushEntry.spec     = pushSpec;
    pushEntry.cls      = instClass_e'(pushClass);
    pushEntry.crCnt    = pushCr;
    pushEntry.gprCnt   = pushGpr;
    pushEntry.fprCnt   = pushFpr;
  end

  retire_ctrl #(.MAX_UPD(MAX_UPD)) u_ctrl (
    .slot0(headSlot0),
    .slot1(headSlot1),
    .ctl  (ctl)
  );

  retire_queue #(.TAG_W(TAG_W)) u_queue (
    .clk        (clk),
    .rstN       (rstN),
    .pushValid  (pushValid),
    .pushEntry  (pushEntry),
    .finishValid(finishValid),
    .finishTag  (finishTag),
    .resolve    (resolve),
    .ctl        (ctl),
    .headSlot0  (headSlot0),
    .headSlot1  (headSlot1),
    .retire0    (retire0),
    .retire1    (retire1),
    .excStrobe  (excStrobe),
    .popCount   (popCount),
    .retireTag  (retireTag)
  );
endmodule

// File: rtl/retire_checks.sv
module retire_checks
  import retire_pkg::*;
#(
  parameter int MAX_UPD = 2
) (
  input logic       clk,
  input logic       rstN,
  input slot_t      headSlot0,
  input slot_t      headSlot1,
  input logic       retire0,
  input logic       retire1,
  input logic       excStrobe,
  input logic [1:0] popCount
);
  p_pair_needs_head_r4: assert property (@(posedge clk) disable iff (!rstN)
    retire1 |-> retire0);

  p_pop_matches_r13: assert property (@(posedge clk) disable iff (!rstN)
    popCount == ({1'b0, retire0} + {1'b0, retire1}));

  p_exc_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    excStrobe |-> (!retire0 && popCount == 2'd0));

  p_head_valid_r12: assert property (@(posedge clk) disable iff (!rstN)
    retire0 |-> $past(headSlot0.valid && headSlot0.finished));

  p_young_finished_r5: assert property (@(posedge clk) disable iff (!rstN)
    retire1 |-> $past(headSlot1.valid && headSlot1.finished));

  p_young_spec_r6: assert property (@(posedge clk) disable iff (!rstN)
    retire1 |-> $past(!headSlot1.spec));

  p_young_exc_r7: assert property (@(posedge clk) disable iff (!rstN)
    retire1 |-> $past(!headSlot1.exc));

  p_young_class_r8: assert property (@(posedge clk) disable iff (!rstN)
    retire1 |-> $past(headSlot1.cls == CLS_INT || headSlot1.cls == CLS_LOAD));

  p_cr_limit_r9: assert property (@(posedge clk) disable iff (!rstN)
    retire1 |-> $past(({1'b0, headSlot0.crCnt} + {1'b0, headSlot1.crCnt}) <= 3'(MAX_UPD)));

  p_gpr_limit_r10: assert property (@(posedge clk) disable iff (!rstN)
    retire1 |-> $past(({1'b0, headSlot0.gprCnt} + {1'b0, headSlot1.gprCnt}) <= 3'(MAX_UPD)));

  p_fpr_limit_r11: assert property (@(posedge clk) disable iff (!rstN)
    retire1 |-> $past(({1'b0, headSlot0.fprCnt} + {1'b0, headSlot1.fprCnt}) <= 3'(MAX_UPD)));
endmodule

bind retire_pair_unit retire_checks #(.MAX_UPD(MAX_UPD)) u_checks (
  .clk      (clk),
  .rstN     (rstN),
  .headSlot0(headSlot0),
  .headSlot1(headSlot1),
  .retire0  (retire0),
  .retire1  (retire1),
  .excStrobe(excStrobe),
  .popCount (popCount)
);

// File: tb/retire_pair_unit_test.sv
`timescale 1ns/1ps
module retire_pair_unit_test;
  localparam int TAG_W = 3;
  localparam int DEPTH = 1 << TAG_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0, pushFinished = 1'b0, pushExc = 1'b0, pushSpec = 1'b0;
  logic [2:0] pushClass = '0;
  logic [1:0] pushCr = '0, pushGpr = '0, pushFpr = '0;
  logic finishValid = 1'b0;
  logic [TAG_W-1:0] finishTag = '0;
  logic resolve = 1'b0;
  logic retire0, retire1, excStrobe;
  logic [1:0] popCount;
  logic [TAG_W-1:0] retireTag;

  always #10 clk = ~clk;

  retire_pair_unit #(.TAG_W(TAG_W), .MAX_UPD(2)) uut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushFinished(pushFinished),
    .pushExc(pushExc), .pushSpec(pushSpec), .pushClass(pushClass), .pushCr(pushCr),
    .pushGpr(pushGpr), .pushFpr(pushFpr), .finishValid(finishValid), .finishTag(finishTag),
    .resolve(resolve), .retire0(retire0), .retire1(retire1), .excStrobe(excStrobe),
    .popCount(popCount), .retireTag(retireTag)
  );

  typedef struct {
    bit fin; bit exc; bit spec; int cls; int cr; int gpr; int fpr;
  } ent_t;

  typedef struct {
    bit pair; int pop; int tag; string req;
  } ev_t;

  ev_t expQ[$];
  int  nCheck = 0;
  int  nFail  = 0;
  bit  done   = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nCheck++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: compares every retirement event against the model queue
  always @(negedge clk) begin
    if (rstN && retire0) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R13", "unexpected retirement tag", int'(retireTag), -1);
      end else begin
        ev_t e;
        e = expQ.pop_front();
        check(retire1 == e.pair, e.req, "retire1", int'(retire1), int'(e.pair));
        check(int'(popCount) == e.pop, e.req, "popCount", int'(popCount), e.pop);
        check(int'(retireTag) == e.tag, e.req, "retireTag", int'(retireTag), e.tag);
      end
    end
  end

  function automatic ent_t mk(input bit fin, input bit exc, input bit spec, input int cls,
                              input int cr, input int gpr, input int fpr);
    ent_t e;
    e.fin = fin; e.exc = exc; e.spec = spec; e.cls = cls; e.cr = cr; e.gpr = gpr; e.fpr = fpr;
    return e;
  endfunction

  function automatic bit pairModel(input ent_t a, input ent_t b, input bit resolved);
    return b.fin && !b.exc && (!b.spec || resolved) && (b.cls == 0 || b.cls == 1)
        && (a.cr + b.cr <= 2) && (a.gpr + b.gpr <= 2) && (a.fpr + b.fpr <= 2);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expQ.delete();
  endtask

  task automatic pushE(input ent_t e);
    pushValid = 1'b1; pushFinished = e.fin; pushExc = e.exc; pushSpec = e.spec;
    pushClass = 3'(e.cls); pushCr = 2'(e.cr); pushGpr = 2'(e.gpr); pushFpr = 2'(e.fpr);
    @(negedge clk);
    pushValid = 1'b0;
  endtask

  task automatic finishT(input int tag);
    finishValid = 1'b1; finishTag = TAG_W'(tag);
    @(negedge clk);
    finishValid = 1'b0;
  endtask

  task automatic drain(input string req);
    repeat (6) @(negedge clk);
    check(expQ.size() == 0, req, "pending expected events", expQ.size(), 0);
  endtask

  // Head A (pushed unfinished) and second entry B reach the decision together
  task automatic runPair(input ent_t a, input ent_t b, input bit doResolve, input string req);
    bit pr;
    doReset();
    a.fin = 1'b0;
    pushE(a);
    pushE(b);
    if (doResolve) begin
      resolve = 1'b1;
      @(negedge clk);
      resolve = 1'b0;
    end
    pr = pairModel(a, b, doResolve);
    expQ.push_back('{pr, pr ? 2 : 1, 0, req});
    if (!pr && b.fin && !b.exc) expQ.push_back('{1'b0, 1, 1, req});
    finishT(0);
    drain(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nCheck++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nCheck - nFail, nCheck);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(!retire0 && !retire1 && !excStrobe, "R1", "strobes in reset", int'(retire0), 0);
    check(popCount == 2'd0 && retireTag == '0, "R1", "popCount/tag in reset", int'(popCount), 0);
    rstN = 1'b1;
    // R12: empty queue never strobes
    repeat (4) @(negedge clk);
    check(!retire0 && !excStrobe, "R12", "empty queue strobe", int'(retire0), 0);

    // R2/R12: lone entry retires alone (second slot invalid)
    doReset();
    pushE(mk(0, 0, 0, 0, 1, 1, 0));
    expQ.push_back('{1'b0, 1, 0, "R12"});
    finishT(0);
    drain("R2");

    // R2/R4/R13: pairs that may retire together
    runPair(mk(0, 0, 0, 3, 0, 1, 1), mk(1, 0, 0, 0, 0, 1, 0), 0, "R2");
    runPair(mk(0, 0, 0, 2, 1, 0, 0), mk(1, 0, 0, 1, 1, 1, 0), 0, "R8");
    // R8: other classes keep the second entry back
    runPair(mk(0, 0, 0, 0, 0, 0, 0), mk(1, 0, 0, 2, 0, 0, 0), 0, "R8");
    runPair(mk(0, 0, 0, 0, 0, 0, 0), mk(1, 0, 0, 3, 0, 0, 0), 0, "R8");
    runPair(mk(0, 0, 0, 0, 0, 0, 0), mk(1, 0, 0, 4, 0, 0, 0), 0, "R8");
    runPair(mk(0, 0, 0, 0, 0, 0, 0), mk(1, 0, 0, 5, 0, 0, 0), 0, "R8");
    // R5: unfinished second entry stays
    runPair(mk(0, 0, 0, 0, 0, 0, 0), mk(0, 0, 0, 0, 0, 0, 0), 0, "R5");
    // R6: speculative blocks the pair; resolve before the decision releases it
    runPair(mk(0, 0, 0, 0, 0, 0, 0), mk(1, 0, 1, 0, 0, 0, 0), 0, "R6");
    runPair(mk(0, 0, 0, 0, 0, 0, 0), mk(1, 0, 1, 1, 0, 0, 0), 1, "R6");
    // R7: exception on the second entry
    runPair(mk(0, 0, 0, 0, 0, 0, 0), mk(1, 1, 0, 0, 0, 0, 0), 0, "R7");
    check(excStrobe == 1'b1, "R7", "second entry exception at head", int'(excStrobe), 1);
    // R9..R11: limits at and past two
    runPair(mk(0, 0, 0, 0, 1, 0, 0), mk(1, 0, 0, 0, 1, 0, 0), 0, "R9");
    runPair(mk(0, 0, 0, 0, 2, 0, 0), mk(1, 0, 0, 0, 1, 0, 0), 0, "R9");
    runPair(mk(0, 0, 0, 0, 0, 2, 0), mk(1, 0, 0, 1, 0, 0, 0), 0, "R10");
    runPair(mk(0, 0, 0, 0, 0, 1, 0), mk(1, 0, 0, 1, 0, 2, 0), 0, "R10");
    runPair(mk(0, 0, 0, 3, 0, 0, 1), mk(1, 0, 0, 0, 0, 0, 1), 0, "R11");
    runPair(mk(0, 0, 0, 3, 0, 0, 2), mk(1, 0, 0, 0, 0, 0, 3), 0, "R11");

    // R3: head exception blocks everything and persists
    doReset();
    pushE(mk(0, 1, 0, 0, 0, 0, 0));
    pushE(mk(1, 0, 0, 0, 0, 0, 0));
    finishT(0);
    @(negedge clk);
    check(excStrobe == 1'b1, "R3", "excStrobe", int'(excStrobe), 1);
    check(!retire0 && !retire1, "R3", "retire while excepting", int'(retire0), 0);
    check(popCount == 2'd0, "R3", "popCount", int'(popCount), 0);
    repeat (3) @(negedge clk);
    check(excStrobe == 1'b1 && !retire0, "R3", "head stays blocked", int'(retire0), 0);

    // R13: streaming singles with tag wrap
    doReset();
    for (int k = 0; k < DEPTH + 4; k++) begin
      expQ.push_back('{1'b0, 1, k % DEPTH, "R13"});
      pushE(mk(1, 0, 0, 0, 0, 0, 0));
    end
    drain("R13");

    done = 1'b1;
    $display("%0d/%0d checks passed", nCheck - nFail, nCheck);
    $finish;
  end
endmodule